// File: doc/BRIEF.md
# Two-Operand NaN Result Selector

This block decides which NaN a two-input single-precision floating-point operation returns when one or both of its operands are NaN. It sorts each 32-bit operand into one of three classes: quiet NaN, signaling NaN or ordinary number. A priority rule fixed at compile time picks one operand. If the picked value is signaling, the block quietens it. The block also raises an invalid-operation flag whenever a signaling operand is present. A run-time default-NaN mode control replaces the returned value with the canonical default NaN. The flag still reflects the operands in that mode.

The block is meant to sit beside an arithmetic datapath. The datapath forwards the operands here once it has found a NaN among them, and then uses the registered result in place of its own. Three priority rules are available:
- Rule set 0 ranks signaling before quiet and A before B.
- Rule set 1 takes A whenever A is any NaN.
- Rule set 2 uses classes, then significand magnitude, then sign.

A second compile-time choice inverts the meaning of the top fraction bit, which separates quiet NaNs from signaling NaNs. Inverting it also changes the default NaN and the way a signaling value is quietened.

The result, the flag and an indication of which operand was selected appear one clock after the input strobe. Operand pairs that contain no NaN are outside the block's contract.

Top module: `nan_pick_unit`

## Requirements
- R1: Each accepted input (in_valid high at a clock edge) produces out_valid high at the next edge, together with out_nan, out_invalid and out_pick_b for it. out_valid is low after any edge where in_valid was low. A synchronous reset (rst high) forces out_valid and out_invalid low.
- R2: An operand is a NaN when its exponent field (bits 30..23) is all ones and its fraction (bits 22..0) is nonzero. With SIG_ONE=0, a NaN is quiet when bit 22 is 1 and signaling when bit 22 is 0. With SIG_ONE=1, these meanings are swapped.
- R3: out_invalid is 1 exactly when at least one operand is a signaling NaN. This holds in default-NaN mode as well.
- R4: When dflt_mode is high, out_nan is the default NaN. The default NaN is 0xFFC00000 for SIG_ONE=0 and ALT_DEFAULT=0, 0x7FC00000 for SIG_ONE=0 and ALT_DEFAULT=1, and 0x7FBFFFFF for SIG_ONE=1.
- R5: Rule set 0 selects the first match in this order: A signaling, B signaling, A quiet, otherwise B.
- R6: Rule set 1 selects A when A is any NaN, otherwise B.
- R7: Rule set 2 selects as follows. A signaling and B quiet: B. A signaling and B an ordinary number: A. A quiet and B signaling or an ordinary number: A. A an ordinary number: B.
- R8: In rule set 2, when both operands are signaling or both are quiet, the operand with the larger magnitude (bits 30..0) is selected. When the magnitudes are equal, the operand with sign bit 0 is selected. If the two words are identical, B is selected.
- R9: A selected signaling NaN is quietened. With SIG_ONE=0 this sets bit 22 and keeps the other bits. With SIG_ONE=1 the default NaN replaces it. A selected quiet NaN passes through unchanged.
- R10: out_pick_b is 1 when B was selected and 0 when A was selected. It reports the selection in default-NaN mode too.
- R11: While in_valid is low, out_nan and out_pick_b keep the values from the last accepted input.

Parameters: RULE_SET (0, 1 or 2), SIG_ONE (0 or 1), ALT_DEFAULT (0 or 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are present this cycle |
| opa | input | 32 | First operand (A) |
| opb | input | 32 | Second operand (B) |
| dflt_mode | input | 1 | Return the default NaN instead of the selected operand |
| out_valid | output | 1 | Result registered from the previous cycle's input |
| out_nan | output | 32 | Selected, quietened or default NaN |
| out_invalid | output | 1 | A signaling operand was present |
| out_pick_b | output | 1 | 1 when operand B was selected |

## Verification
All state in this block is the single output register stage, so any wrong internal value appears on the ports exactly one cycle after the input that caused it. Two kinds of fault can be told apart at the ports, because out_pick_b shows the selection and out_nan shows the quietening. A wrong classification shows up in out_invalid and in the selected operand. A wrong tie-break shows up only on pairs of equal magnitude. For that reason, the operand sweep includes pairs of equal magnitude with opposite signs, pairs that are entirely equal, and mixed pairs of quiet NaNs, signaling NaNs and ordinary numbers, all under both polarities.

// File: rtl/nanp_pkg.sv
package nanp_pkg;

    localparam int SP_W   = 32;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = SP_W - EXP_W - 1;
    localparam int QB     = FRAC_W - 1;   // fraction MSB: quiet/signaling marker

    typedef enum logic [1:0] {
        CLS_NUM   = 2'd0,
        CLS_QUIET = 2'd1,
        CLS_SIG   = 2'd2
    } nan_cls_e;

    typedef struct packed {
        logic            vld;
        logic            inv;
        logic            pick_b;
        logic [SP_W-1:0] res;
    } nanp_state_t;

    function automatic logic [SP_W-1:0] dflt_nan(input bit sig_one, input bit alt);
        logic [SP_W-1:0] v;
        if (sig_one) begin
            v = {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};
        end else begin
            v = {~alt, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
        end
        return v;
    endfunction

endpackage

// File: rtl/nanp_classify.sv
module nanp_classify
    import nanp_pkg::*;
#(
    parameter bit SIG_ONE = 1'b0
) (
    input  logic [SP_W-1:0] op,
    output nan_cls_e        cls
);
    localparam logic [SP_W-1:0] HI_THR = {{(EXP_W+1){1'b1}}, {(SP_W-EXP_W-1){1'b0}}};
    localparam logic [EXP_W:0]  LO_PAT = {{EXP_W{1'b1}}, 1'b0};

    logic [SP_W-1:0] shifted;
    logic            hi_test;
    logic            lo_test;
    logic            is_quiet;
    logic            is_sig;

    assign shifted = {op[SP_W-2:0], 1'b0};
    assign hi_test = (shifted >= HI_THR);
    assign lo_test = (op[SP_W-2 -: EXP_W+1] == LO_PAT) && (|op[QB-1:0]);

    generate
        if (SIG_ONE) begin : g_inverted
            assign is_quiet = lo_test;
            assign is_sig   = hi_test;
        end else begin : g_normal
            assign is_quiet = hi_test;
            assign is_sig   = lo_test;
        end
    endgenerate

    always_comb begin
        if (is_sig) begin
            cls = CLS_SIG;
        end else if (is_quiet) begin
            cls = CLS_QUIET;
        end else begin
            cls = CLS_NUM;
        end
    end

endmodule

// File: rtl/nanp_priority.sv
module nanp_priority
    import nanp_pkg::*;
#(
    parameter int RULE_SET = 2
) (
    input  logic [SP_W-1:0] opa,
    input  logic [SP_W-1:0] opb,
    input  nan_cls_e        cls_a,
    input  nan_cls_e        cls_b,
    output logic            pick_b
);
    logic [SP_W-1:0] mag_a;
    logic [SP_W-1:0] mag_b;
    logic            a_larger;
    logic            a_sig;
    logic            a_qnan;
    logic            b_sig;
    logic            b_qnan;

    assign mag_a  = {opa[SP_W-2:0], 1'b0};
    assign mag_b  = {opb[SP_W-2:0], 1'b0};
    assign a_sig  = (cls_a == CLS_SIG);
    assign a_qnan = (cls_a == CLS_QUIET);
    assign b_sig  = (cls_b == CLS_SIG);
    assign b_qnan = (cls_b == CLS_QUIET);

    always_comb begin
        if (mag_a != mag_b) begin
            a_larger = (mag_a > mag_b);
        end else begin
            a_larger = (opa < opb);
        end
    end

    always_comb begin
        case (RULE_SET)
            0: begin
                if (a_sig)       pick_b = 1'b0;
                else if (b_sig)  pick_b = 1'b1;
                else if (a_qnan) pick_b = 1'b0;
                else             pick_b = 1'b1;
            end
            1: begin
                pick_b = !(a_sig || a_qnan);
            end
            default: begin
                if (a_sig) begin
                    if (b_sig) pick_b = !a_larger;
                    else       pick_b = b_qnan;
                end else if (a_qnan) begin
                    if (b_sig || !b_qnan) pick_b = 1'b0;
                    else                  pick_b = !a_larger;
                end else begin
                    pick_b = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/nanp_quiet.sv
module nanp_quiet
    import nanp_pkg::*;
#(
    parameter bit SIG_ONE     = 1'b0,
    parameter bit ALT_DEFAULT = 1'b0
) (
    input  logic [SP_W-1:0] op,
    input  logic            is_sig,
    output logic [SP_W-1:0] res
);
    localparam logic [SP_W-1:0] DEF_NAN = dflt_nan(SIG_ONE, ALT_DEFAULT);
    localparam logic [SP_W-1:0] Q_MASK  = {{(SP_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

    generate
        if (SIG_ONE) begin : g_replace
            assign res = is_sig ? DEF_NAN : op;
        end else begin : g_setbit
            assign res = is_sig ? (op | Q_MASK) : op;
        end
    endgenerate

endmodule

// File: rtl/nan_pick_unit.sv
module nan_pick_unit
    import nanp_pkg::*;
#(
    parameter int RULE_SET    = 2,
    parameter bit SIG_ONE     = 1'b0,
    parameter bit ALT_DEFAULT = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [SP_W-1:0] opa,
    input  logic [SP_W-1:0] opb,
    input  logic            dflt_mode,
    output logic            out_valid,
    output logic [SP_W-1:0] out_nan,
    output logic            out_invalid,
    output logic            out_pick_b
);
    localparam logic [SP_W-1:0] DEF_NAN = dflt_nan(SIG_ONE, ALT_DEFAULT);

    nan_cls_e        cls_a;
    nan_cls_e        cls_b;
    logic            sel_b;
    logic [SP_W-1:0] chosen;
    logic            chosen_sig;
    logic [SP_W-1:0] quieted;
    nanp_state_t     st_d;
    nanp_state_t     st_q;

    nanp_classify #(.SIG_ONE(SIG_ONE)) u_cls_a (.op(opa), .cls(cls_a));
    nanp_classify #(.SIG_ONE(SIG_ONE)) u_cls_b (.op(opb), .cls(cls_b));

    nanp_priority #(.RULE_SET(RULE_SET)) u_prio (
        .opa    (opa),
        .opb    (opb),
        .cls_a  (cls_a),
        .cls_b  (cls_b),
        .pick_b (sel_b)
    );

    assign chosen     = sel_b ? opb : opa;
    assign chosen_sig = sel_b ? (cls_b == CLS_SIG) : (cls_a == CLS_SIG);

    nanp_quiet #(.SIG_ONE(SIG_ONE), .ALT_DEFAULT(ALT_DEFAULT)) u_quiet (
        .op     (chosen),
        .is_sig (chosen_sig),
        .res    (quieted)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.inv    = (cls_a == CLS_SIG) || (cls_b == CLS_SIG);
            st_d.pick_b = sel_b;
            st_d.res    = dflt_mode ? DEF_NAN : quieted;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.vld <= 1'b0;
            st_q.inv <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.vld;
    assign out_invalid = st_q.inv;
    assign out_pick_b  = st_q.pick_b;
    assign out_nan     = st_q.res;

endmodule

// File: rtl/nanp_chk.sv
module nanp_chk
    import nanp_pkg::*;
#(
    parameter int RULE_SET    = 2,
    parameter bit SIG_ONE     = 1'b0,
    parameter bit ALT_DEFAULT = 1'b0
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [SP_W-1:0] opa,
    input logic [SP_W-1:0] opb,
    input logic            dflt_mode,
    input logic            out_valid,
    input logic [SP_W-1:0] out_nan,
    input logic            out_invalid,
    input logic            out_pick_b
);
    localparam logic [SP_W-1:0] DEF_NAN = dflt_nan(SIG_ONE, ALT_DEFAULT);
    localparam logic [SP_W-1:0] Q_MASK  = {{(SP_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic a_nan, b_nan, a_sig, b_sig;
    logic seen_q;

    assign a_nan = (&opa[SP_W-2:FRAC_W]) && (|opa[FRAC_W-1:0]);
    assign b_nan = (&opb[SP_W-2:FRAC_W]) && (|opb[FRAC_W-1:0]);
    assign a_sig = a_nan && (opa[QB] == SIG_ONE);
    assign b_sig = b_nan && (opb[QB] == SIG_ONE);

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else if (out_valid) seen_q <= 1'b1;
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);  // R1
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);  // R1
    AST_FLAG_ON_SIGNAL: assert property (@(posedge clk) disable iff (rst)
        in_valid && (a_sig || b_sig) |=> out_invalid);  // R3
    AST_NO_FLAG_QUIET: assert property (@(posedge clk) disable iff (rst)
        in_valid && !a_sig && !b_sig |=> !out_invalid);  // R3
    AST_DEFAULT_OUT: assert property (@(posedge clk) disable iff (rst)
        in_valid && dflt_mode |=> out_nan == DEF_NAN);  // R4
    AST_RULE0_ASIG: assert property (@(posedge clk) disable iff (rst)
        (RULE_SET == 0) && in_valid && a_sig |=> !out_pick_b);  // R5
    AST_RULE0_BSIG: assert property (@(posedge clk) disable iff (rst)
        (RULE_SET == 0) && in_valid && !a_sig && b_sig |=> out_pick_b);  // R5
    AST_RULE1_ANAN: assert property (@(posedge clk) disable iff (rst)
        (RULE_SET == 1) && in_valid && a_nan |=> !out_pick_b);  // R6
    AST_SET_QBIT: assert property (@(posedge clk) disable iff (rst)
        !SIG_ONE && in_valid && !dflt_mode && (a_nan || b_nan)
        |=> out_nan == ((out_pick_b ? $past(opb) : $past(opa)) | Q_MASK));  // R9
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        seen_q && !in_valid |=> $stable(out_nan) && $stable(out_pick_b));  // R11

endmodule

bind nan_pick_unit nanp_chk #(
    .RULE_SET    (RULE_SET),
    .SIG_ONE     (SIG_ONE),
    .ALT_DEFAULT (ALT_DEFAULT)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .opa         (opa),
    .opb         (opb),
    .dflt_mode   (dflt_mode),
    .out_valid   (out_valid),
    .out_nan     (out_nan),
    .out_invalid (out_invalid),
    .out_pick_b  (out_pick_b)
);

// File: tb/nan_pick_unit_tb_top.sv
module nan_pick_unit_tb_top;

    localparam int NI = 4;
    localparam int NV = 12;
    localparam int CFG_RULE [NI] = '{2, 0, 1, 0};
    localparam bit CFG_INV  [NI] = '{1'b0, 1'b1, 1'b0, 1'b0};
    localparam bit CFG_ALT  [NI] = '{1'b0, 1'b0, 1'b1, 1'b1};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iv = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        dm = 1'b0;

    logic        vld [NI];
    logic [31:0] res [NI];
    logic        flg [NI];
    logic        pkb [NI];

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    nan_pick_unit #(.RULE_SET(2), .SIG_ONE(1'b0), .ALT_DEFAULT(1'b0)) dut_i (
        .clk(clk), .rst(rst), .in_valid(iv), .opa(opa), .opb(opb), .dflt_mode(dm),
        .out_valid(vld[0]), .out_nan(res[0]), .out_invalid(flg[0]), .out_pick_b(pkb[0]));
    nan_pick_unit #(.RULE_SET(0), .SIG_ONE(1'b1), .ALT_DEFAULT(1'b0)) dut_r0inv (
        .clk(clk), .rst(rst), .in_valid(iv), .opa(opa), .opb(opb), .dflt_mode(dm),
        .out_valid(vld[1]), .out_nan(res[1]), .out_invalid(flg[1]), .out_pick_b(pkb[1]));
    nan_pick_unit #(.RULE_SET(1), .SIG_ONE(1'b0), .ALT_DEFAULT(1'b1)) dut_r1 (
        .clk(clk), .rst(rst), .in_valid(iv), .opa(opa), .opb(opb), .dflt_mode(dm),
        .out_valid(vld[2]), .out_nan(res[2]), .out_invalid(flg[2]), .out_pick_b(pkb[2]));
    nan_pick_unit #(.RULE_SET(0), .SIG_ONE(1'b0), .ALT_DEFAULT(1'b1)) dut_r0 (
        .clk(clk), .rst(rst), .in_valid(iv), .opa(opa), .opb(opb), .dflt_mode(dm),
        .out_valid(vld[3]), .out_nan(res[3]), .out_invalid(flg[3]), .out_pick_b(pkb[3]));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit is_nan(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
    endfunction

    function automatic logic [31:0] def_of(input bit inv, input bit alt);
        if (inv) return 32'h7FBF_FFFF;
        return alt ? 32'h7FC0_0000 : 32'hFFC0_0000;
    endfunction

    // Reference model written from the requirements R2..R10
    function automatic void model(input int rule, input bit inv, input bit alt,
                                  input logic [31:0] a, input logic [31:0] b, input bit dmode,
                                  output logic [31:0] r, output bit fl, output bit pb);
        bit an, bn, as_, bs_, aq, bq, alg;
        logic [31:0] p;
        bit psig;
        an  = is_nan(a);
        bn  = is_nan(b);
        as_ = an && (a[22] == inv);
        bs_ = bn && (b[22] == inv);
        aq  = an && !as_;
        bq  = bn && !bs_;
        if (a[30:0] == b[30:0]) alg = (a[31] == 1'b0) && (b[31] == 1'b1);
        else                    alg = (a[30:0] > b[30:0]);
        case (rule)
            0: pb = as_ ? 1'b0 : bs_ ? 1'b1 : aq ? 1'b0 : 1'b1;
            1: pb = !an;
            default: begin
                if (as_)     pb = bs_ ? !alg : bq;
                else if (aq) pb = (bs_ || !bn) ? 1'b0 : !alg;
                else         pb = 1'b1;
            end
        endcase
        fl   = as_ || bs_;
        p    = pb ? b : a;
        psig = pb ? bs_ : as_;
        if (dmode)     r = def_of(inv, alt);
        else if (psig) r = inv ? def_of(inv, alt) : (p | 32'h0040_0000);
        else           r = p;
    endfunction

    function automatic string pick_tag(input int rule, input logic [31:0] a,
                                       input logic [31:0] b, input bit dmode);
        if (dmode)     return "R10";
        if (rule == 0) return "R5";
        if (rule == 1) return "R6";
        if (a[30:0] == b[30:0]) return "R8";
        return "R7";
    endfunction

    logic [31:0] vals [NV];

    task automatic run_pair(input logic [31:0] a, input logic [31:0] b, input bit dmode);
        logic [31:0] er [NI];
        bit ef [NI];
        bit ep [NI];
        @(negedge clk);
        opa = a; opb = b; dm = dmode; iv = 1'b1;
        for (int k = 0; k < NI; k++) model(CFG_RULE[k], CFG_INV[k], CFG_ALT[k], a, b, dmode, er[k], ef[k], ep[k]);
        @(negedge clk);
        for (int k = 0; k < NI; k++) begin
            chk("R1 out_valid", {31'd0, vld[k]}, 32'd1);
            chk(dmode ? "R4 result" : "R9 result", res[k], er[k]);
            chk(CFG_INV[k] ? "R2 invalid flag" : "R3 invalid flag", {31'd0, flg[k]}, {31'd0, ef[k]});
            chk(pick_tag(CFG_RULE[k], a, b, dmode), {31'd0, pkb[k]}, {31'd0, ep[k]});
        end
        // idle cycle with changed operands: outputs hold
        iv = 1'b0; opa = ~a; opb = ~b; dm = ~dmode;
        @(negedge clk);
        for (int k = 0; k < NI; k++) begin
            chk("R1 valid low", {31'd0, vld[k]}, 32'd0);
            chk("R11 hold result", res[k], er[k]);
            chk("R11 hold pick", {31'd0, pkb[k]}, {31'd0, ep[k]});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        vals = '{32'h7FC0_0001, 32'hFFC0_0001, 32'h7FE0_0000, 32'hFFC0_0000,
                 32'h7F80_0001, 32'hFF80_0001, 32'h7FA0_0000, 32'hFFA0_0000,
                 32'h0000_0000, 32'h7F80_0000, 32'hBF80_0000, 32'h3F80_0000};
        // reset holds valid and flag low even with input strobe high
        iv = 1'b1; opa = 32'h7F80_0001; opb = 32'h7F80_0001;
        repeat (3) @(negedge clk);
        for (int k = 0; k < NI; k++) begin
            chk("R1 reset valid", {31'd0, vld[k]}, 32'd0);
            chk("R1 reset flag", {31'd0, flg[k]}, 32'd0);
        end
        iv = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        for (int m = 0; m < 2; m++)
            for (int i = 0; i < NV; i++)
                for (int j = 0; j < NV; j++)
                    if (is_nan(vals[i]) || is_nan(vals[j]))
                        run_pair(vals[i], vals[j], m[0]);

        // mid-run reset clears valid and flag
        @(negedge clk);
        iv = 1'b1; opa = 32'h7F80_0001; opb = 32'h7FA0_0000; dm = 1'b0;
        @(negedge clk);
        iv = 1'b0; rst = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NI; k++) begin
            chk("R1 reset valid late", {31'd0, vld[k]}, 32'd0);
            chk("R1 reset flag late", {31'd0, flg[k]}, 32'd0);
        end
        rst = 1'b0;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule